// File: doc/BRIEF.md
# BCD Prescaler and Calendar Counter

This block is the timekeeping core of a real-time clock. It counts enable pulses from a 32.768 kHz timebase in a binary prescaler. The prescaler yields a 128 Hz square wave for trimming the oscillator and a 1 Hz square wave that clocks a seconds counter. A minute signal is high during the second half of every minute. Each falling edge of the minute signal advances a chain of BCD counters for minutes, hours, day of month and month.

Software sets the time by writing any of the four calendar fields directly. Two strobes act on the seconds stage. One clears the prescaler and the seconds with no effect on the minutes. The other rounds the time to the nearest whole minute. Leap years are not tracked: February always ends after day 28, unless day 29 has been written directly.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset, minutes and hours read 00, day and month read 01, the seconds count is 0, and the seconds, minute and tuning outputs are low.
- R2: The prescaler advances only in cycles with `tickEn` high. `secOut` is the prescaler's top bit, so it is low for the first half of each 2^PRE_W enabled cycles and high for the second half. The seconds count steps 0 to 59 and back to 0 on each falling edge of `secOut`.
- R3: `minOut` is high exactly while the seconds count is 30 or more. Apart from the effect of the two strobes, it changes state only in the cycle in which `secOut` falls.
- R4: `tuneOut` is prescaler bit PRE_W-8, a square wave with a period of 256 enabled cycles (bit 0 when PRE_W is below 8).
- R5: Each falling edge of `minOut` advances the BCD minutes field from 00 to 59. The step from 59 back to 00 carries into the hours.
- R6: Hours count 00 to 23 in BCD. The step from 23 back to 00 carries into the day.
- R7: The day wraps to 01 after 28 when the month is 02, after 30 when the month is 04, 06, 09 or 11, and after 31 in every other month. Any day at or above the limit wraps, so a written 29 in February goes to 01 at the next day carry.
- R8: Months count 01 to 12 in BCD. The step from 12 back to 01 follows a day wrap.
- R9: `presetStb` clears the prescaler and the seconds count in the next cycle. The minutes do not advance, even when `minOut` falls. It takes priority over `tickEn` and `adjustStb`.
- R10: `adjustStb` clears the prescaler and the seconds count. The minutes advance by one only when the seconds count was 30 or more. Below 30 the minutes stay unchanged.
- R11: A write with `wrEn` high loads `wrData` into the field chosen by `wrSel` in the next cycle. The codes are 0 minutes, 1 hours, 2 day, 3 month. Only the low 7, 6, 6 and 5 bits are kept, and the upper bits read 0. A write takes priority over a carry into the same field. Carries into the other fields are taken from the values held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One enable per 32.768 kHz timebase period |
| presetStb | input | 1 | Clear prescaler and seconds, no minute carry |
| adjustStb | input | 1 | Round to nearest minute |
| wrEn | input | 1 | Direct field write strobe |
| wrSel | input | 2 | Field select: 0 min, 1 hour, 2 day, 3 month |
| wrData | input | 8 | BCD data to write |
| tuneOut | output | 1 | 128 Hz tuning square wave |
| secOut | output | 1 | 1 Hz square wave |
| minOut | output | 1 | Per-minute square wave |
| secCount | output | 6 | Binary seconds count 0..59 |
| minBcd | output | 8 | BCD minutes |
| hourBcd | output | 8 | BCD hours |
| dayBcd | output | 8 | BCD day of month |
| monBcd | output | 8 | BCD month |

## Verification
The carries at the top of the chain are hard to reach from the ports. Through the natural prescaler, a month-end or year-end rollover takes hours or days of timebase. The bench reaches each case quickly. It writes the four fields while the seconds count is already past 30, then fires the time-adjust strobe, which forces a single minute carry through the whole chain. The bench also builds the core with a short prescaler so that a natural minute rollover fits in its run.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int NUM_FIELDS = 4;
  localparam int FLD_MIN  = 0;
  localparam int FLD_HOUR = 1;
  localparam int FLD_DAY  = 2;
  localparam int FLD_MON  = 3;
  localparam int SEC_W    = 6;
  localparam int SEC_LAST = 59;
  localparam int SEC_HALF = 30;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] ldMask;   // one-hot direct load per field
    logic                  minStep;  // advance the minutes field this cycle
  } calCtl_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic [7:0] fieldMask(input int idx);
    case (idx)
      FLD_MIN:  return 8'h7F;
      FLD_MON:  return 8'h1F;
      default:  return 8'h3F;
    endcase
  endfunction

  function automatic logic [7:0] fieldFloor(input int idx);
    return (idx >= FLD_DAY) ? 8'h01 : 8'h00;
  endfunction

endpackage

// File: rtl/rtc_prescale_ctl.sv
module rtc_prescale_ctl
  import rtc_cal_pkg::*;
#(
  parameter int PRE_W = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             presetStb,
  input  logic             adjustStb,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  output calCtl_t          ctl,
  output logic             tuneOut,
  output logic             secOut,
  output logic             minOut,
  output logic [SEC_W-1:0] secCount
);

  localparam int TUNE_BIT = (PRE_W >= 8) ? PRE_W - 8 : 0;

  logic [PRE_W-1:0] preQ;
  logic [SEC_W-1:0] secQ;
  logic             clrAll;
  logic             secFall;
  logic             secAtEnd;
  logic             secHigh;

  assign clrAll   = presetStb | adjustStb;
  assign secAtEnd = (secQ >= SEC_W'(SEC_LAST));
  assign secHigh  = (secQ >= SEC_W'(SEC_HALF));
  assign secFall  = tickEn & (&preQ) & ~clrAll;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preQ <= '0;
      secQ <= '0;
    end else if (clrAll) begin
      preQ <= '0;
      secQ <= '0;
    end else if (tickEn) begin
      preQ <= preQ + 1'b1;
      if (secFall) secQ <= secAtEnd ? '0 : secQ + 1'b1;
    end
  end

  always_comb begin
    ctl.minStep = (secFall & secAtEnd) | (adjustStb & ~presetStb & secHigh);
    for (int i = 0; i < NUM_FIELDS; i++)
      ctl.ldMask[i] = wrEn & (wrSel == 2'(i));
  end

  generate
    if (PRE_W >= 8) begin : g_tune_tap
      assign tuneOut = preQ[TUNE_BIT];
    end else begin : g_tune_short
      assign tuneOut = preQ[0];
    end
  endgenerate

  assign secOut   = preQ[PRE_W-1];
  assign minOut   = secHigh;
  assign secCount = secQ;

endmodule

// File: rtl/rtc_calendar_dp.sv
module rtc_calendar_dp
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  calCtl_t    ctl,
  input  logic [7:0] wrData,
  output logic [7:0] minBcd,
  output logic [7:0] hourBcd,
  output logic [7:0] dayBcd,
  output logic [7:0] monBcd
);

  logic [7:0]      fldQ [NUM_FIELDS];
  logic [7:0]      lim  [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] adv;
  logic [NUM_FIELDS-1:0] atLim;

  always_comb begin
    lim[FLD_MIN]  = 8'h59;
    lim[FLD_HOUR] = 8'h23;
    lim[FLD_MON]  = 8'h12;
    case (fldQ[FLD_MON])
      8'h02:                      lim[FLD_DAY] = 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: lim[FLD_DAY] = 8'h30;
      default:                    lim[FLD_DAY] = 8'h31;
    endcase
    for (int i = 0; i < NUM_FIELDS; i++)
      atLim[i] = (fldQ[i] >= lim[i]);
    adv[0] = ctl.minStep;
    for (int i = 1; i < NUM_FIELDS; i++)
      adv[i] = adv[i-1] & atLim[i-1];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (!rstN)
        fldQ[i] <= fieldFloor(i);
      else if (ctl.ldMask[i])
        fldQ[i] <= wrData & fieldMask(i);
      else if (adv[i])
        fldQ[i] <= atLim[i] ? fieldFloor(i) : bcdInc(fldQ[i]);
    end
  end

  assign minBcd  = fldQ[FLD_MIN];
  assign hourBcd = fldQ[FLD_HOUR];
  assign dayBcd  = fldQ[FLD_DAY];
  assign monBcd  = fldQ[FLD_MON];

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int PRE_W = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       presetStb,
  input  logic       adjustStb,
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  input  logic [7:0] wrData,
  output logic       tuneOut,
  output logic       secOut,
  output logic       minOut,
  output logic [5:0] secCount,
  output logic [7:0] minBcd,
  output logic [7:0] hourBcd,
  output logic [7:0] dayBcd,
  output logic [7:0] monBcd
);

  calCtl_t ctl;

  rtc_prescale_ctl #(.PRE_W(PRE_W)) u_ctl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .presetStb(presetStb), .adjustStb(adjustStb),
    .wrEn(wrEn), .wrSel(wrSel), .ctl(ctl),
    .tuneOut(tuneOut), .secOut(secOut), .minOut(minOut),
    .secCount(secCount)
  );

  rtc_calendar_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData),
    .minBcd(minBcd), .hourBcd(hourBcd), .dayBcd(dayBcd), .monBcd(monBcd)
  );

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic       clk,
  input logic       rstN,
  input logic       presetStb,
  input logic       adjustStb,
  input logic       wrEn,
  input logic [1:0] wrSel,
  input logic [7:0] wrData,
  input logic       secOut,
  input logic       minOut,
  input logic [5:0] secCount,
  input logic [7:0] minBcd
);

  a_r2_sec_bound: assert property (@(posedge clk) disable iff (!rstN)
    secCount < 6'd60);

  a_r3_min_edge: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(minOut) && !$past(presetStb) && !$past(adjustStb)) |-> $fell(secOut));

  a_r5_min_advance: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(minOut) && !$past(presetStb) && !$past(wrEn)) |-> (minBcd != $past(minBcd)));

  a_r9_preset_clear: assert property (@(posedge clk) disable iff (!rstN)
    presetStb |=> (secCount == 6'd0 && !secOut && !minOut));

  a_r10_adjust_low: assert property (@(posedge clk) disable iff (!rstN)
    (adjustStb && !presetStb && secCount < 6'd30 && !wrEn) |=> $stable(minBcd));

  a_r11_write_min: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd0) |=> (minBcd == {1'b0, $past(wrData[6:0])}));

endmodule

bind rtc_calendar_core rtc_calendar_chk u_chk (
  .clk(clk), .rstN(rstN), .presetStb(presetStb), .adjustStb(adjustStb),
  .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .secOut(secOut),
  .minOut(minOut), .secCount(secCount), .minBcd(minBcd)
);

// File: tb/sim_rtc_calendar_core.sv
`timescale 1ns/1ps
module sim_rtc_calendar_core;

  localparam int PW  = 8;
  localparam int SPS = 1 << PW;   // enabled cycles per second
  localparam int NV  = 11;

  // {mon, day, hour, min} written, then {mon, day, hour, min} after one carry
  localparam logic [63:0] VEC [NV] = '{
    {32'h03070512, 32'h03070513},
    {32'h03070559, 32'h03070600},
    {32'h03072359, 32'h03080000},
    {32'h02282359, 32'h03010000},
    {32'h02292359, 32'h03010000},
    {32'h04302359, 32'h05010000},
    {32'h05302359, 32'h05310000},
    {32'h12312359, 32'h01010000},
    {32'h11302359, 32'h12010000},
    {32'h09190959, 32'h09191000},
    {32'h01091439, 32'h01091440}
  };

  logic clk = 1'b0;
  logic rstN, tickEn, presetStb, adjustStb, wrEn;
  logic [1:0] wrSel;
  logic [7:0] wrData;
  logic tuneOut, secOut, minOut;
  logic [5:0] secCount;
  logic [7:0] minBcd, hourBcd, dayBcd, monBcd;

  int nChk = 0;
  int nBad = 0;

  always #2 clk = ~clk;

  rtc_calendar_core #(.PRE_W(PW)) u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .presetStb(presetStb),
    .adjustStb(adjustStb), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .tuneOut(tuneOut), .secOut(secOut), .minOut(minOut), .secCount(secCount),
    .minBcd(minBcd), .hourBcd(hourBcd), .dayBcd(dayBcd), .monBcd(monBcd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doPreset();
    presetStb = 1'b1; step(1); presetStb = 1'b0;
  endtask

  task automatic doAdjust();
    adjustStb = 1'b1; step(1); adjustStb = 1'b0;
  endtask

  task automatic doWrite(input logic [1:0] sel, input logic [7:0] d);
    wrEn = 1'b1; wrSel = sel; wrData = d; step(1); wrEn = 1'b0;
  endtask

  task automatic waitHalf();
    while (secCount < 6'd30) step(1);
  endtask

  function automatic logic [31:0] cal();
    return {monBcd, dayBcd, hourBcd, minBcd};
  endfunction

  initial begin
    repeat (180000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    rstN = 1'b0; tickEn = 1'b0; presetStb = 1'b0; adjustStb = 1'b0;
    wrEn = 1'b0; wrSel = 2'd0; wrData = 8'h00;
    step(3);
    rstN = 1'b1;
    step(1);
    chk("R1 calendar", cal(), 32'h01010000);
    chk("R1 seconds/outs", {23'd0, secCount, tuneOut, secOut, minOut}, 32'd0);

    // R4 tuning tap is bit 0 for PRE_W=8
    tickEn = 1'b1;
    step(1); chk("R4 tune high", {31'd0, tuneOut}, 32'd1);
    step(1); chk("R4 tune low", {31'd0, tuneOut}, 32'd0);

    // R2 enable gating
    step(1);
    tickEn = 1'b0;
    step(5); chk("R2 hold without enable", {31'd0, tuneOut}, 32'd1);
    tickEn = 1'b1;

    // R2 seconds wave and count
    doPreset();
    step(SPS/2 - 1); chk("R2 secOut low half", {31'd0, secOut}, 32'd0);
    step(1);         chk("R2 secOut high half", {31'd0, secOut}, 32'd1);
    step(SPS/2 - 1); chk("R2 sec before fall", {26'd0, secCount}, 32'd0);
    step(1);         chk("R2 sec after fall", {25'd0, secCount, secOut}, {25'd0, 6'd1, 1'b0});

    // R3 minute wave rises at 30
    step(29*SPS - 1); chk("R3 minOut at 29", {25'd0, secCount, minOut}, {25'd0, 6'd29, 1'b0});
    step(1);          chk("R3 minOut at 30", {25'd0, secCount, minOut}, {25'd0, 6'd30, 1'b1});

    // R9 preset above 30: no carry
    doPreset();
    chk("R9 preset clears", {secCount, minOut, minBcd}, {6'd0, 1'b0, 8'h00});

    // R10 adjust below 30: no carry
    step(10*SPS);
    doAdjust();
    chk("R10 adjust low no carry", {secCount, minBcd}, {6'd0, 8'h00});

    // R5 natural minute rollover
    step(60*SPS - 1); chk("R5 before wrap", {secCount, minBcd}, {6'd59, 8'h00});
    step(1);          chk("R5 after wrap", {secCount, minOut, minBcd}, {6'd0, 1'b0, 8'h01});

    // R11 write beats carry, other carries from old values
    doWrite(2'd0, 8'h59);
    doWrite(2'd1, 8'h05);
    waitHalf();
    adjustStb = 1'b1; wrEn = 1'b1; wrSel = 2'd0; wrData = 8'h20;
    step(1);
    adjustStb = 1'b0; wrEn = 1'b0;
    chk("R11 write priority", {hourBcd, minBcd}, 32'h00000620);
    doWrite(2'd1, 8'hE3);
    chk("R11 upper bits masked", {24'd0, hourBcd}, 32'h23);

    // R6 R7 R8 R10 calendar carries through the adjust strobe
    for (int v = 0; v < NV; v++) begin
      waitHalf();
      doWrite(2'd0, VEC[v][39:32]);
      doWrite(2'd1, VEC[v][47:40]);
      doWrite(2'd3, VEC[v][63:56]);
      doWrite(2'd2, VEC[v][55:48]);
      doAdjust();
      chk("R6 R7 R8 R10 carry vector", cal(), VEC[v][31:0]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule